// File: doc/BRIEF.md
# Card Controller Status and Interrupt Unit

This block keeps the status word of a memory-card host controller and turns it into two interrupt lines. Command and data engines report events on a set bus. Each event bit is sticky and stays set until software clears it through a write-one-to-clear register. The upper part of the status word holds FIFO level flags. These flags follow a level input from the data path, and software cannot clear them.

Each interrupt output has its own mask register. An output is high whenever at least one status bit enabled by its mask is set. Status, masks and interrupts share one register port, which also carries the FIFO count view, the FIFO data window and a block of identification bytes.

The block also throttles refill on the read side. When software pops a word from the FIFO data window, a hold flag is raised and the data engine stops refilling. The hold is released when software next reads the status word or the FIFO count. Both of those reads return the value held before the access updates any state.

Top module: `mmc_status_irq`

## Requirements
- R1: Reset clears the event bits, both mask registers and the refill hold. Both interrupt outputs are low after reset.
- R2: Setting bit k of `evt_set` (k in 0..10) makes status bit k read as 1 from the next cycle on. The bit stays set until it is cleared.
- R3: A write to offset 0x38 clears every status bit 10..0 whose write-data bit is 1. Status bits 31..11 are not affected.
- R4: If a status bit receives a set and a clear in the same cycle, the set wins and the bit reads 1.
- R5: The mask registers sit at 0x3C (line 0) and 0x40 (line 1) and read back as written. `irq[i]` is high exactly when status AND mask i is nonzero, one cycle after the register write or event that changed it.
- R6: Status bits 31..11 show `lvl_in` one cycle late. Bit 11 + j shows `lvl_in[j]`.
- R7: A read anywhere in the word-aligned window 0x80..0xBC returns `fifo_rdata`, pulses `fifo_pop` in the same cycle and sets `refill_hold` from the next cycle on.
- R8: A read of status (0x34) or FIFO count (0x48) returns the value from before that cycle's update. Such a read drops `refill_hold` from the next cycle on.
- R9: A read of 0x48 returns (byte_remain + 3) >> 2. This is the remaining byte count rounded up to whole 32-bit words.
- R10: A read at 0xFE0 + 4*n (n = 0..7) returns the identification bytes 0x81, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 for n = 0..7, in the low byte.
- R11: Reads of unmapped offsets return 0. Writes to the status offset or to unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 12 | Register byte offset |
| rd_en | input | 1 | Read strobe, data returned in the same cycle |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid while rd_en is high |
| evt_set | input | 11 | Sticky event set pulses from the command and data paths |
| lvl_in | input | 21 | FIFO level flags for status bits 31..11 |
| byte_remain | input | 16 | Bytes left in the current data transfer |
| fifo_rdata | input | 32 | Head word of the receive FIFO |
| fifo_pop | output | 1 | Pops the FIFO head on a data-window read |
| refill_hold | output | 1 | Holds off data-engine refill until the next status poll |
| irq | output | 2 | Masked interrupt lines |

## Verification
A wrong sticky or clear path shows up as a wrong status read-back on the first read after the event. It also shows as an interrupt level that is off one cycle after the change. A refill hold stuck in the wrong state is visible on `refill_hold` in the cycle after the data-window or poll read. It would otherwise surface only as a stalled or overrun transfer much later. The bench therefore samples that flag directly after each read that should change it. It reads the status word in the same cycle as a new event, which separates the pre-update value from the post-update value.

// File: rtl/mmc_sirq_pkg.sv
package mmc_sirq_pkg;
   localparam int OFS_STATUS = 'h034;
   localparam int OFS_CLEAR  = 'h038;
   localparam int OFS_MASK0  = 'h03C;
   localparam int MASK_STEP  = 4;
   localparam int OFS_FCOUNT = 'h048;
   localparam int OFS_WIN_LO = 'h080;
   localparam int OFS_WIN_HI = 'h0BC;
   localparam int OFS_ID_LO  = 'hFE0;
   localparam int OFS_ID_HI  = 'hFFF;

   function automatic logic [7:0] id_byte(input logic [2:0] k);
      case (k)
         3'd0: id_byte = 8'h81;
         3'd1: id_byte = 8'h11;
         3'd2: id_byte = 8'h04;
         3'd3: id_byte = 8'h00;
         3'd4: id_byte = 8'h0D;
         3'd5: id_byte = 8'hF0;
         3'd6: id_byte = 8'h05;
         default: id_byte = 8'hB1;
      endcase
   endfunction
endpackage

// File: rtl/sirq_status_word.sv
module sirq_status_word #(
   parameter int DATA_W   = 32,
   parameter int EVT_BITS = 11,
   localparam int LVL_W   = DATA_W - EVT_BITS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr_stb,
   input  logic [EVT_BITS-1:0] clr_bits,
   input  logic [EVT_BITS-1:0] evt_set,
   input  logic [LVL_W-1:0]    lvl_in,
   output logic [DATA_W-1:0]   status
);
   logic [EVT_BITS-1:0] evt_q;
   logic [LVL_W-1:0]    lvl_q;
   logic [EVT_BITS-1:0] clr_eff;

   assign clr_eff = clr_stb ? clr_bits : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         evt_q <= '0;
         lvl_q <= '0;
      end else begin
         evt_q <= (evt_q & ~clr_eff) | evt_set;
         lvl_q <= lvl_in;
      end
   end

   assign status = {lvl_q, evt_q};

   // R2
   sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_set != '0) |=> ((status[EVT_BITS-1:0] & $past(evt_set)) == $past(evt_set)));
   // R3
   clear_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_stb && evt_set == '0) |=> ((status[EVT_BITS-1:0] & $past(clr_bits)) == '0));
   // R6
   level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_stb |=> (status[DATA_W-1:EVT_BITS] == $past(lvl_in)));
endmodule

// File: rtl/sirq_mask_line.sv
module sirq_mask_line #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 12,
   parameter int OFS    = 'h03C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] status,
   output logic [DATA_W-1:0] mask,
   output logic              irq
);
   logic sel;

   assign sel = (addr == ADDR_W'(OFS));

   always_ff @(posedge clk) begin
      if (!rst_n)             mask <= '0;
      else if (wr_en && sel)  mask <= wr_data;
   end

   assign irq = |(status & mask);

   // R5
   masked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '0) |-> !irq);
   // R5
   needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (status != '0));
endmodule

// File: rtl/sirq_refill_gate.sv
module sirq_refill_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic win_rd,
   input  logic poll_rd,
   output logic hold
);
   always_ff @(posedge clk) begin
      if (!rst_n)       hold <= 1'b0;
      else if (win_rd)  hold <= 1'b1;
      else if (poll_rd) hold <= 1'b0;
   end

   // R7
   hold_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_rd |=> hold);
   // R8
   hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (poll_rd && !win_rd) |=> !hold);
endmodule

// File: rtl/mmc_status_irq.sv
module mmc_status_irq #(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 12,
   parameter int EVT_BITS = 11,
   parameter int CNT_W    = 16,
   parameter int NUM_IRQ  = 2,
   localparam int LVL_W   = DATA_W - EVT_BITS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   addr,
   input  logic                rd_en,
   input  logic                wr_en,
   input  logic [DATA_W-1:0]   wr_data,
   output logic [DATA_W-1:0]   rd_data,
   input  logic [EVT_BITS-1:0] evt_set,
   input  logic [LVL_W-1:0]    lvl_in,
   input  logic [CNT_W-1:0]    byte_remain,
   input  logic [DATA_W-1:0]   fifo_rdata,
   output logic                fifo_pop,
   output logic                refill_hold,
   output logic [NUM_IRQ-1:0]  irq
);
   import mmc_sirq_pkg::*;

   generate
      if (EVT_BITS < 1 || EVT_BITS >= DATA_W) begin : g_bad_evt
         $error("EVT_BITS must lie inside the status word");
      end
      if (CNT_W >= DATA_W) begin : g_bad_cnt
         $error("CNT_W must be narrower than DATA_W");
      end
      if (NUM_IRQ < 1 || DATA_W < 8 || ADDR_W < 12) begin : g_bad_cfg
         $error("need at least one line, byte-wide data and a 4 KiB window");
      end
   endgenerate

   logic [DATA_W-1:0] status;
   logic [DATA_W-1:0] mask_arr [NUM_IRQ];
   logic              clr_stb, win_hit, id_hit, win_rd, poll_rd;
   logic [CNT_W:0]    cnt_words;

   assign clr_stb = wr_en && (addr == ADDR_W'(OFS_CLEAR));
   assign win_hit = (addr >= ADDR_W'(OFS_WIN_LO)) && (addr <= ADDR_W'(OFS_WIN_HI))
                    && (addr[1:0] == 2'b00);
   assign id_hit  = (addr >= ADDR_W'(OFS_ID_LO)) && (addr <= ADDR_W'(OFS_ID_HI));
   assign win_rd  = rd_en && win_hit;
   assign poll_rd = rd_en && ((addr == ADDR_W'(OFS_STATUS)) || (addr == ADDR_W'(OFS_FCOUNT)));
   assign fifo_pop = win_rd;
   assign cnt_words = ({1'b0, byte_remain} + (CNT_W+1)'(3)) >> 2;

   sirq_status_word #(.DATA_W(DATA_W), .EVT_BITS(EVT_BITS)) u_status (
      .clk(clk), .rst_n(rst_n), .clr_stb(clr_stb),
      .clr_bits(wr_data[EVT_BITS-1:0]), .evt_set(evt_set),
      .lvl_in(lvl_in), .status(status));

   generate
      for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_line
         sirq_mask_line #(.DATA_W(DATA_W), .ADDR_W(ADDR_W),
                          .OFS(OFS_MASK0 + MASK_STEP*gi)) u_line (
            .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
            .wr_data(wr_data), .status(status),
            .mask(mask_arr[gi]), .irq(irq[gi]));
      end
   endgenerate

   sirq_refill_gate u_gate (
      .clk(clk), .rst_n(rst_n), .win_rd(win_rd), .poll_rd(poll_rd),
      .hold(refill_hold));

   always_comb begin
      rd_data = '0;
      if (rd_en) begin
         if (addr == ADDR_W'(OFS_STATUS))      rd_data = status;
         else if (addr == ADDR_W'(OFS_FCOUNT)) rd_data = DATA_W'(cnt_words);
         else if (win_hit)                     rd_data = fifo_rdata;
         else if (id_hit)                      rd_data = DATA_W'(id_byte(addr[4:2]));
         else begin
            for (int i = 0; i < NUM_IRQ; i++) begin
               if (addr == ADDR_W'(OFS_MASK0 + MASK_STEP*i)) rd_data = mask_arr[i];
            end
         end
      end
   end

   // R7 R8
   always_comb begin
      single_read_kind_chk: assert (!(win_rd && poll_rd));
   end
endmodule

// File: tb/tb_mmc_status_irq.sv
`timescale 1ns/1ps
module tb_mmc_status_irq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] addr = '0;
   logic        rd_en = 1'b0, wr_en = 1'b0;
   logic [31:0] wr_data = '0, rd_data, fifo_rdata = '0;
   logic [10:0] evt_set = '0;
   logic [20:0] lvl_in = '0;
   logic [15:0] byte_remain = '0;
   logic        fifo_pop, refill_hold;
   logic [1:0]  irq;
   int total = 0, bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   mmc_status_irq dut (.*);

   // {req[3:0], op[1:0] (1 write, 2 read-check), addr[11:0], data[31:0], evt[10:0], exp[31:0]}
   localparam int NV = 20;
   localparam logic [92:0] VEC [NV] = '{
      {4'd5,  2'd1, 12'h03C, 32'h0000_0041, 11'h000, 32'h0},          // R5 mask0
      {4'd2,  2'd1, 12'h010, 32'h0000_0000, 11'h005, 32'h0},          // R2 events 0,2
      {4'd2,  2'd2, 12'h034, 32'h0,         11'h000, 32'h0000_0005},  // R2
      {4'd5,  2'd2, 12'h03C, 32'h0,         11'h000, 32'h0000_0041},  // R5
      {4'd3,  2'd1, 12'h038, 32'h0000_0001, 11'h000, 32'h0},          // R3
      {4'd3,  2'd2, 12'h034, 32'h0,         11'h000, 32'h0000_0004},  // R3
      {4'd4,  2'd1, 12'h038, 32'hFFFF_FFFF, 11'h400, 32'h0},          // R4 set vs clear
      {4'd4,  2'd2, 12'h034, 32'h0,         11'h000, 32'h0000_0400},  // R4
      {4'd11, 2'd1, 12'h034, 32'hFFFF_FFFF, 11'h000, 32'h0},          // R11 status write
      {4'd11, 2'd2, 12'h034, 32'h0,         11'h000, 32'h0000_0400},  // R11
      {4'd10, 2'd2, 12'hFE0, 32'h0,         11'h000, 32'h81},         // R10
      {4'd10, 2'd2, 12'hFE4, 32'h0,         11'h000, 32'h11},
      {4'd10, 2'd2, 12'hFE8, 32'h0,         11'h000, 32'h04},
      {4'd10, 2'd2, 12'hFEC, 32'h0,         11'h000, 32'h00},
      {4'd10, 2'd2, 12'hFF0, 32'h0,         11'h000, 32'h0D},
      {4'd10, 2'd2, 12'hFF4, 32'h0,         11'h000, 32'hF0},
      {4'd10, 2'd2, 12'hFF8, 32'h0,         11'h000, 32'h05},
      {4'd10, 2'd2, 12'hFFC, 32'h0,         11'h000, 32'hB1},
      {4'd11, 2'd2, 12'h044, 32'h0,         11'h000, 32'h0},          // R11 unmapped
      {4'd5,  2'd2, 12'h040, 32'h0,         11'h000, 32'h0}           // R5 mask1 untouched
   };

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [10:0] e);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1; evt_set = e;
      @(posedge clk); #1;
      wr_en = 1'b0; evt_set = '0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [10:0] e,
                     output logic [31:0] v, output logic pop);
      @(negedge clk);
      addr = a; rd_en = 1'b1; evt_set = e;
      #1 v = rd_data; pop = fifo_pop;
      @(posedge clk); #1;
      rd_en = 1'b0; evt_set = '0;
   endtask

   task automatic pulse_evt(input logic [10:0] e);
      @(negedge clk); evt_set = e;
      @(posedge clk); #1 evt_set = '0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #1000000;
      total++; bad++;
      $display("FAIL watchdog: got hung expected finish");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      logic p;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      rd(12'h034, 11'h0, v, p); chk("R1 status", v, 32'h0);
      rd(12'h03C, 11'h0, v, p); chk("R1 mask0", v, 32'h0);
      rd(12'h040, 11'h0, v, p); chk("R1 mask1", v, 32'h0);
      @(negedge clk);
      chk("R1 irq", {30'h0, irq}, 32'h0);
      chk("R1 hold", {31'h0, refill_hold}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][88:87] == 2'd1) wr(VEC[i][86:75], VEC[i][74:43], VEC[i][42:32]);
         else begin
            rd(VEC[i][86:75], VEC[i][42:32], v, p);
            chk($sformatf("R%0d vector %0d", VEC[i][92:89], i), v, VEC[i][31:0]);
         end
      end

      // R5 independent lines: status=0x400, mask0=0x41
      @(negedge clk); chk("R5 irq0 low", {31'h0, irq[0]}, 32'h0);
      wr(12'h040, 32'h0000_0400, 11'h0);
      @(negedge clk); chk("R5 irq both", {30'h0, irq}, 32'h2);
      pulse_evt(11'h001);
      @(negedge clk); chk("R5 irq0 event", {30'h0, irq}, 32'h3);
      wr(12'h038, 32'h0000_0401, 11'h0);
      @(negedge clk); chk("R5 irq cleared", {30'h0, irq}, 32'h0);

      // R6 level bits
      @(negedge clk); lvl_in = 21'h2;
      @(posedge clk); #1;
      rd(12'h034, 11'h0, v, p); chk("R6 level", v, 32'h0000_1000);
      wr(12'h038, 32'hFFFF_FFFF, 11'h0);
      rd(12'h034, 11'h0, v, p); chk("R3 level kept", v, 32'h0000_1000);
      wr(12'h03C, 32'h0000_1000, 11'h0);
      @(negedge clk); chk("R6 level irq", {30'h0, irq}, 32'h1);
      lvl_in = '0;
      wr(12'h03C, 32'h0, 11'h0);

      // R9 word count
      byte_remain = 16'd5;    rd(12'h048, 11'h0, v, p); chk("R9 five", v, 32'd2);
      byte_remain = 16'd4;    rd(12'h048, 11'h0, v, p); chk("R9 four", v, 32'd1);
      byte_remain = 16'd0;    rd(12'h048, 11'h0, v, p); chk("R9 zero", v, 32'd0);
      byte_remain = 16'hFFFF; rd(12'h048, 11'h0, v, p); chk("R9 max", v, 32'h4000);

      // R7 data window and hold
      fifo_rdata = 32'hCAFE_0001;
      rd(12'h080, 11'h0, v, p);
      chk("R7 data", v, 32'hCAFE_0001); chk("R7 pop", {31'h0, p}, 32'h1);
      chk("R7 hold set", {31'h0, refill_hold}, 32'h1);
      rd(12'h0BC, 11'h0, v, p); chk("R7 top pop", {31'h0, p}, 32'h1);
      rd(12'h0C0, 11'h0, v, p); chk("R7 outside", {31'h0, p}, 32'h0);
      chk("R7 hold kept", {31'h0, refill_hold}, 32'h1);
      // R8 pre-update read and release
      rd(12'h034, 11'h002, v, p); chk("R8 pre-update", v, 32'h0);
      chk("R8 hold released", {31'h0, refill_hold}, 32'h0);
      rd(12'h034, 11'h0, v, p); chk("R8 post-update", v, 32'h2);
      rd(12'h0A0, 11'h0, v, p);
      rd(12'h048, 11'h0, v, p); chk("R8 count release", {31'h0, refill_hold}, 32'h0);

      // R1 reset mid-run
      wr(12'h03C, 32'hFFFF_FFFF, 11'h0);
      rd(12'h080, 11'h0, v, p);
      @(negedge clk); rst_n = 1'b0;
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      chk("R1 hold after reset", {31'h0, refill_hold}, 32'h0);
      chk("R1 irq after reset", {30'h0, irq}, 32'h0);
      rd(12'h034, 11'h0, v, p); chk("R1 status after reset", v, 32'h0);
      rd(12'h03C, 11'h0, v, p); chk("R1 mask after reset", v, 32'h0);
      finish_run();
   end
endmodule